// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the code fetch address of a small accumulator-style processor core. The address is 13 bits wide. A decoder upstream drives one-cycle strobes that ask for a sequential step, a subroutine call or a subroutine return. The block keeps the current fetch address in a register and holds return addresses in an 8-entry hardware stack. It also raises a flush flag for the extra cycle that every call and every return costs.

A call target is built from two parts. The low 11 bits come from the immediate operand of the instruction. The top two bits come from bits 4 and 3 of a page-latch register held elsewhere in the core. The block only reads that latch and never writes it. A return does not use the page latch: it takes the whole 13-bit address from the top of the stack. The stack pointer wraps. A push into a full stack overwrites the oldest entry without reporting it.

Top module: `paged_pc_unit`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) sets `fetch_addr` to 0, clears `flush`, and leaves the return stack empty. A return issued straight after reset loads address 0.
- R2: When `step` is high and no call, return or flush cycle is active, `fetch_addr` increases by one at the next edge. It wraps from 0x1FFF to 0x0000.
- R3: When `step`, `call_go` and `ret_go` are all low and no flush cycle is active, `fetch_addr` keeps its value.
- R4: A call loads `fetch_addr` with `page_latch[4:3]` in bits 12:11 and `call_imm[10:0]` in bits 10:0. All other `page_latch` bits have no effect.
- R5: A call pushes the current `fetch_addr` plus one, taken modulo 2^13, before the address changes. A later matching return loads that value.
- R6: In the cycle after a call or a return, `flush` is 1 and `fetch_addr` holds. All strobes given in that cycle are ignored. `flush` is never high for two cycles in a row.
- R7: A return loads all 13 bits of `fetch_addr` from the top of the stack, whatever value `page_latch` has.
- R8: Nested calls are undone in last-in, first-out order.
- R9: The stack holds 8 entries. A ninth push overwrites the oldest entry. After 9 pushes, 8 returns give the 8 newest addresses, newest first, and a ninth return gives the newest address again.
- R10: When `call_go` and `ret_go` are both high in the same cycle, the call takes effect and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance to the next sequential address |
| call_go | input | 1 | Subroutine call strobe |
| ret_go | input | 1 | Subroutine return strobe |
| call_imm | input | 11 | In-page call target |
| page_latch | input | 8 | Page-latch register contents; bits 4:3 supply the upper target bits |
| fetch_addr | output | 13 | Current code fetch address |
| flush | output | 1 | High during the dead second cycle of a call or return |

## Verification
Some rules are checked by the assertions on every cycle:
- the call target is built from the page bits and the immediate;
- a flush follows every call and every return, and never two flushes in a row;
- the address holds during a flush and during a stall;
- a step adds exactly one;
- the stack pointer moves one place on each push and each pop;
- a return loads the stack output.

Other rules can only be shown by scenarios in the bench, because they depend on values stored many cycles earlier:
- the value that was pushed, including the wrap at the top of the address space;
- last-in, first-out ordering;
- the overwrite of the oldest entry after nine calls;
- a return from an empty stack after reset.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_CALL = 2'd2,
    ACT_RET  = 2'd3
  } pc_act_e;
endpackage

// File: rtl/ppc_seq_ctl.sv
// Decides the action of each instruction cycle and owns the flush cycle
// that follows every change of control flow.
module ppc_seq_ctl
  import ppc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    step,
  input  logic    call_go,
  input  logic    ret_go,
  output pc_act_e act,
  output logic    flush
);
  logic flush_q;

  // Call outranks return; the dead cycle swallows every strobe.
  always_comb begin
    if (rst || flush_q)   act = ACT_HOLD;
    else if (call_go)     act = ACT_CALL;
    else if (ret_go)      act = ACT_RET;
    else if (step)        act = ACT_STEP;
    else                  act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) flush_q <= 1'b0;
    else     flush_q <= (act == ACT_CALL) || (act == ACT_RET);
  end

  assign flush = flush_q;
endmodule

// File: rtl/ppc_ret_stack.sv
// Circular return-address stack. DEPTH must be a power of two so that
// the pointer wraps on its own; a push into a full stack overwrites the
// oldest entry.
module ppc_ret_stack #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 13,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] top_data,
  output logic [PTR_W-1:0]  sp
);
  logic [DATA_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]  sp_q;
  logic [DEPTH-1:0]  slot_we;
  logic [PTR_W-1:0]  rd_idx;

  // One write enable per slot, selected by the pointer.
  for (genvar g = 0; g < DEPTH; g++) begin : g_we
    assign slot_we[g] = push && (sp_q == PTR_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (slot_we[i]) slots[i] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       sp_q <= '0;
    else if (push) sp_q <= sp_q + PTR_W'(1);
    else if (pop)  sp_q <= sp_q - PTR_W'(1);
  end

  assign rd_idx   = sp_q - PTR_W'(1);
  assign top_data = slots[rd_idx];
  assign sp       = sp_q;
endmodule

// File: rtl/ppc_pc_path.sv
// The PC register and the arithmetic that forms its next value.
module ppc_pc_path
  import ppc_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int IMM_W    = 11,
  parameter int LATCH_W  = 8,
  parameter int PAGE_LSB = 3,
  localparam int PAGE_W  = ADDR_W - IMM_W
) (
  input  logic               clk,
  input  logic               rst,
  input  pc_act_e            act,
  input  logic [IMM_W-1:0]   imm,
  input  logic [LATCH_W-1:0] page_latch,
  input  logic [ADDR_W-1:0]  pop_addr,
  output logic [ADDR_W-1:0]  pc,
  output logic [ADDR_W-1:0]  ret_addr
);
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;

  // The next sequential address, wrapping at the top of the space.
  function automatic logic [ADDR_W-1:0] f_seq(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // Page bits on top, in-page immediate below.
  function automatic logic [ADDR_W-1:0] f_target(
    input logic [LATCH_W-1:0] latch,
    input logic [IMM_W-1:0]   k
  );
    return {latch[PAGE_LSB +: PAGE_W], k};
  endfunction

  always_comb begin
    unique case (act)
      ACT_STEP: pc_d = f_seq(pc_q);
      ACT_CALL: pc_d = f_target(page_latch, imm);
      ACT_RET:  pc_d = pop_addr;
      default:  pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign pc       = pc_q;
  assign ret_addr = f_seq(pc_q);
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
  import ppc_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int IMM_W    = 11,
  parameter int LATCH_W  = 8,
  parameter int PAGE_LSB = 3,
  parameter int DEPTH    = 8,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               call_go,
  input  logic               ret_go,
  input  logic [IMM_W-1:0]   call_imm,
  input  logic [LATCH_W-1:0] page_latch,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic               flush
);
  pc_act_e           act;
  logic [ADDR_W-1:0] pop_addr;
  logic [ADDR_W-1:0] ret_addr;
  logic [PTR_W-1:0]  sp;

  // Events brought out by name for the checker.
  logic call_fire, ret_fire, step_fire;
  assign call_fire = (act == ACT_CALL);
  assign ret_fire  = (act == ACT_RET);
  assign step_fire = (act == ACT_STEP);

  ppc_seq_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .call_go (call_go),
    .ret_go  (ret_go),
    .act     (act),
    .flush   (flush)
  );

  ppc_ret_stack #(.DEPTH(DEPTH), .DATA_W(ADDR_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (call_fire),
    .pop       (ret_fire),
    .push_data (ret_addr),
    .top_data  (pop_addr),
    .sp        (sp)
  );

  ppc_pc_path #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .LATCH_W(LATCH_W), .PAGE_LSB(PAGE_LSB)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .imm        (call_imm),
    .page_latch (page_latch),
    .pop_addr   (pop_addr),
    .pc         (fetch_addr),
    .ret_addr   (ret_addr)
  );
endmodule

// File: rtl/paged_pc_unit_chk.sv
module paged_pc_unit_chk #(
  parameter int ADDR_W   = 13,
  parameter int IMM_W    = 11,
  parameter int LATCH_W  = 8,
  parameter int PAGE_LSB = 3,
  parameter int PTR_W    = 3,
  localparam int PAGE_W  = ADDR_W - IMM_W
) (
  input logic               clk,
  input logic               rst,
  input logic               step,
  input logic               call_go,
  input logic               ret_go,
  input logic [IMM_W-1:0]   call_imm,
  input logic [LATCH_W-1:0] page_latch,
  input logic [ADDR_W-1:0]  fetch_addr,
  input logic               flush,
  input logic               call_fire,
  input logic               ret_fire,
  input logic               step_fire,
  input logic [ADDR_W-1:0]  pop_addr,
  input logic [PTR_W-1:0]   sp
);
  assert_call_target_R4: assert property (@(posedge clk) disable iff (rst)
    call_fire |=> fetch_addr == {$past(page_latch[PAGE_LSB +: PAGE_W]), $past(call_imm)});

  assert_flush_follows_R6: assert property (@(posedge clk) disable iff (rst)
    (call_fire || ret_fire) |=> flush);

  assert_flush_holds_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> $stable(fetch_addr));

  assert_single_flush_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  assert_step_inc_R2: assert property (@(posedge clk) disable iff (rst)
    step_fire |=> fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(1)));

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!flush && !step && !call_go && !ret_go) |=> $stable(fetch_addr));

  assert_call_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (!flush && call_go && ret_go) |-> (call_fire && !ret_fire));

  assert_push_advance_R5: assert property (@(posedge clk) disable iff (rst)
    call_fire |=> sp == PTR_W'($past(sp) + PTR_W'(1)));

  assert_pop_load_R7: assert property (@(posedge clk) disable iff (rst)
    ret_fire |=> (fetch_addr == $past(pop_addr)) && (sp == PTR_W'($past(sp) - PTR_W'(1))));
endmodule

bind paged_pc_unit paged_pc_unit_chk #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .LATCH_W(LATCH_W),
  .PAGE_LSB(PAGE_LSB), .PTR_W(PTR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step       (step),
  .call_go    (call_go),
  .ret_go     (ret_go),
  .call_imm   (call_imm),
  .page_latch (page_latch),
  .fetch_addr (fetch_addr),
  .flush      (flush),
  .call_fire  (call_fire),
  .ret_fire   (ret_fire),
  .step_fire  (step_fire),
  .pop_addr   (pop_addr),
  .sp         (sp)
);

// File: tb/paged_pc_unit_test.sv
module paged_pc_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 17;

  logic        clk = 1'b0;
  logic        rst, step, call_go, ret_go;
  logic [10:0] call_imm;
  logic [7:0]  page_latch;
  logic [12:0] fetch_addr;
  logic        flush;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_pc_unit uut (
    .clk(clk), .rst(rst), .step(step), .call_go(call_go), .ret_go(ret_go),
    .call_imm(call_imm), .page_latch(page_latch),
    .fetch_addr(fetch_addr), .flush(flush)
  );

  // Vector: {step, call, ret, imm[10:0], page[7:0], expected pc[12:0], expected flush}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1,1'b0,1'b0,11'h000,8'h00,13'h0001,1'b0}, // R2 step
    {1'b1,1'b0,1'b0,11'h000,8'h00,13'h0002,1'b0}, // R2 step
    {1'b0,1'b0,1'b0,11'h000,8'h00,13'h0002,1'b0}, // R3 stall
    {1'b0,1'b1,1'b0,11'h123,8'h18,13'h1923,1'b1}, // R4 call, page bits 11
    {1'b1,1'b1,1'b0,11'h055,8'h00,13'h1923,1'b0}, // R6 strobes ignored in flush
    {1'b1,1'b0,1'b0,11'h000,8'h00,13'h1924,1'b0}, // R2
    {1'b0,1'b0,1'b1,11'h000,8'h00,13'h0003,1'b1}, // R5 return to pushed pc+1
    {1'b1,1'b0,1'b0,11'h000,8'h00,13'h0003,1'b0}, // R6 step ignored in flush
    {1'b1,1'b0,1'b0,11'h000,8'h00,13'h0004,1'b0}, // R2
    {1'b0,1'b1,1'b0,11'h7FF,8'hE7,13'h07FF,1'b1}, // R4 other latch bits ignored
    {1'b0,1'b0,1'b0,11'h000,8'h00,13'h07FF,1'b0}, // R6
    {1'b0,1'b1,1'b1,11'h005,8'h08,13'h0805,1'b1}, // R10 call wins
    {1'b0,1'b0,1'b0,11'h000,8'h00,13'h0805,1'b0}, // R6
    {1'b0,1'b0,1'b1,11'h000,8'hFF,13'h0800,1'b1}, // R7 R8 inner return
    {1'b0,1'b0,1'b0,11'h000,8'h00,13'h0800,1'b0}, // R6
    {1'b0,1'b0,1'b1,11'h000,8'h00,13'h0005,1'b1}, // R8 outer return
    {1'b0,1'b0,1'b0,11'h000,8'h00,13'h0005,1'b0}  // R6
  };

  task automatic check(input string req, input logic [12:0] exp_pc, input logic exp_fl);
    checks++;
    if (fetch_addr !== exp_pc || flush !== exp_fl) begin
      fails++;
      $display("FAIL %s: pc=%h flush=%b expected pc=%h flush=%b",
               req, fetch_addr, flush, exp_pc, exp_fl);
    end
  endtask

  task automatic cyc(input logic s, input logic c, input logic r,
                     input logic [10:0] k, input logic [7:0] p);
    step = s; call_go = c; ret_go = r; call_imm = k; page_latch = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 11'h0, 8'h0);
    cyc(1'b0, 1'b0, 1'b0, 11'h0, 8'h0);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; step = 1'b0; call_go = 1'b0; ret_go = 1'b0;
    call_imm = '0; page_latch = '0;
    @(negedge clk);
    do_reset();
    check("R1 reset state", 13'h0000, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32:22], VEC[i][21:14]);
      check($sformatf("vector %0d", i), VEC[i][13:1], VEC[i][0]);
    end

    // R1: return from an empty stack after reset lands on 0
    cyc(1'b1, 1'b0, 1'b0, 11'h0, 8'h0);
    cyc(1'b1, 1'b0, 1'b0, 11'h0, 8'h0);
    do_reset();
    check("R1 reset after activity", 13'h0000, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 11'h0, 8'h18);
    check("R1 empty-stack return", 13'h0000, 1'b1);

    // R2: sequential wrap at the top of the address space
    do_reset();
    cyc(1'b0, 1'b1, 1'b0, 11'h7FF, 8'h18);
    check("R4 top target", 13'h1FFF, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 11'h0, 8'h0);
    cyc(1'b1, 1'b0, 1'b0, 11'h0, 8'h0);
    check("R2 wrap", 13'h0000, 1'b0);

    // R5: pushed return address wraps too
    do_reset();
    cyc(1'b0, 1'b1, 1'b0, 11'h7FF, 8'h18);
    cyc(1'b0, 1'b0, 1'b0, 11'h0, 8'h0);
    cyc(1'b0, 1'b1, 1'b0, 11'h010, 8'h00);
    check("R5 nested call", 13'h0010, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 11'h0, 8'h0);
    cyc(1'b0, 1'b0, 1'b1, 11'h0, 8'h0);
    check("R5 wrapped return addr", 13'h0000, 1'b1);

    // R9: nine calls into an eight-entry stack
    do_reset();
    for (int j = 1; j <= 9; j++) begin
      cyc(1'b0, 1'b1, 1'b0, 11'(j * 16), 8'h00);
      cyc(1'b0, 1'b0, 1'b0, 11'h0, 8'h0);
    end
    check("R9 after nine calls", 13'h0090, 1'b0);
    for (int j = 1; j <= 8; j++) begin
      cyc(1'b0, 1'b0, 1'b1, 11'h0, 8'h00);
      check($sformatf("R9 return %0d", j), 13'((9 - j) * 16 + 1), 1'b1);
      cyc(1'b0, 1'b0, 1'b0, 11'h0, 8'h0);
    end
    cyc(1'b0, 1'b0, 1'b1, 11'h0, 8'h00);
    check("R9 ninth return wraps to newest", 13'h0081, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule